// File: doc/BRIEF.md
# Byte-Aligned Serial-to-Parallel Converter with Free-Running Byte Clock

This block takes a recovered serial bit stream, one bit per cycle of the bit-rate clock, and delivers bytes on an 8-bit parallel bus. A byte-boundary strobe comes from an external framing function. When it is pulsed, the bit on the serial input in that cycle becomes the first bit of a new byte. Without that strobe, bytes are cut every eight bits, counting from the first bit after reset.

The parallel side is paced by a byte clock that is generated by dividing the bit clock by eight. Realignment never resets or disturbs this divider. The block brings the byte clock out as a 50 % duty level, together with a one-cycle enable that marks its falling edge. Assembled bytes pass through three registers in a chain: a shift register, a holding register that loads at byte boundaries, and an output register that loads on the byte clock's falling edge. The byte clock therefore stays clean through reframes. The price is a latency that varies with the phase between the boundary and the byte clock. When the framing function is unused, the strobe input must be tied low so that the boundary never moves.

Top module: `s2p_byte_aligner`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `par_out` is 0, `pclk_out` is 1 and `pclk_fall` is 0. Counting the first cycle after reset as cycle 0, the first `pclk_fall` pulse occurs in cycle 4.
- R2: `pclk_out` has a period of exactly 8 cycles. It is high in cycles n with n mod 8 in 0..3 and low when n mod 8 is in 4..7. A realign pulse never changes this.
- R3: `pclk_fall` is high for exactly one cycle per period, in the first cycle in which `pclk_out` is low (n mod 8 = 4).
- R4: `par_out` changes only in a cycle in which `pclk_fall` is high. In every other cycle it holds its previous value.
- R5: The first serial bit of a byte appears in bit 7 (the MSB) of `par_out`, and the last bit appears in bit 0.
- R6: While `realign` stays low, byte boundaries fall every 8 bits. The first byte after reset consists of the bits received in cycles 0..7.
- R7: A `realign` pulse in cycle k makes the bit received in cycle k the first bit of a new byte. Any byte still being assembled at that moment is discarded and never reaches `par_out`.
- R8: In a cycle n with `pclk_fall` high, `par_out` holds the most recent complete byte whose last bit was received in cycle n-3 or earlier. If no byte has completed yet, it holds 0.
- R9: The time from a byte's first serial bit (cycle k) to the first cycle in which that byte is visible on `par_out` is between 10 and 17 cycles inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit, one per cycle |
| realign | input | 1 | Byte-boundary strobe; the current bit starts a new byte |
| pclk_out | output | 1 | Free-running byte clock, 50 % duty |
| pclk_fall | output | 1 | One-cycle enable marking the byte clock's falling edge |
| par_out | output | 8 | Parallel output byte, first bit in the MSB |

## Verification
The bench sweeps the realign pulse across all eight phases of the byte clock. It checks that the latency always stays within 10 to 17 cycles; a design that loaded the output at the boundary rather than on the clock edge would fall outside this window, or would change `par_out` between falling edges. It also fires realign in the middle of a byte and in the same cycle as a byte's last bit. A converter that failed to discard the partial byte would present a spurious value. A converter that let realign touch the divider would be caught by the per-cycle check of the byte clock's period and phase. A directed single-one byte exposes a reversed bit order.

// File: rtl/s2p_pkg.sv
package s2p_pkg;
  localparam int unsigned S2P_BYTE_W = 8;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } s2p_lvl_e;
endpackage

// File: rtl/s2p_deser_front.sv
module s2p_deser_front
  import s2p_pkg::*;
#(
  parameter int unsigned BYTE_W = S2P_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              realign,
  output logic [BYTE_W-1:0] hold_q
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam int unsigned LAST  = BYTE_W - 1;

  logic [BYTE_W-1:0] shift_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              bnd_q;
  logic              last_bit;

  // the current bit closes a byte unless a realign restarts the count here
  always_comb last_bit = (bit_cnt_q == CNT_W'(LAST)) && !realign;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q   <= '0;
      bit_cnt_q <= '0;
      bnd_q     <= 1'b0;
      hold_q    <= '0;
    end else begin
      shift_q <= {shift_q[BYTE_W-2:0], ser_in};
      if (realign)
        bit_cnt_q <= CNT_W'(1);
      else if (bit_cnt_q == CNT_W'(LAST))
        bit_cnt_q <= '0;
      else
        bit_cnt_q <= bit_cnt_q + 1'b1;
      bnd_q <= last_bit;
      if (bnd_q)
        hold_q <= shift_q;
    end
  end
endmodule

// File: rtl/s2p_pclk_gen.sv
module s2p_pclk_gen
  import s2p_pkg::*;
#(
  parameter int unsigned BYTE_W = S2P_BYTE_W
) (
  input  logic clk,
  input  logic rst,
  output logic pclk_q,
  output logic fall_q,
  output logic load_now
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam int unsigned HALF  = BYTE_W / 2;
  localparam int unsigned LAST  = BYTE_W - 1;

  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] div_nxt;

  always_comb begin
    div_nxt  = (div_q == CNT_W'(LAST)) ? '0 : div_q + 1'b1;
    load_now = (div_nxt == CNT_W'(HALF));
  end

  // divider has no input besides reset: realignment cannot reach it
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      pclk_q <= LVL_HIGH;
      fall_q <= 1'b0;
    end else begin
      div_q  <= div_nxt;
      pclk_q <= (div_nxt < CNT_W'(HALF)) ? LVL_HIGH : LVL_LOW;
      fall_q <= load_now;
    end
  end
endmodule

// File: rtl/s2p_out_stage.sv
module s2p_out_stage
  import s2p_pkg::*;
#(
  parameter int unsigned BYTE_W = S2P_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] hold_in,
  output logic [BYTE_W-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst)
      out_q <= '0;
    else if (load)
      out_q <= hold_in;
  end
endmodule

// File: rtl/s2p_byte_aligner.sv
module s2p_byte_aligner
  import s2p_pkg::*;
#(
  parameter int unsigned BYTE_W = S2P_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              realign,
  output logic              pclk_out,
  output logic              pclk_fall,
  output logic [BYTE_W-1:0] par_out
);
  logic [BYTE_W-1:0] hold_w;
  logic              load_w;

  s2p_deser_front #(.BYTE_W(BYTE_W)) u_front (
    .clk     (clk),
    .rst     (rst),
    .ser_in  (ser_in),
    .realign (realign),
    .hold_q  (hold_w)
  );

  s2p_pclk_gen #(.BYTE_W(BYTE_W)) u_pclk (
    .clk      (clk),
    .rst      (rst),
    .pclk_q   (pclk_out),
    .fall_q   (pclk_fall),
    .load_now (load_w)
  );

  s2p_out_stage #(.BYTE_W(BYTE_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (load_w),
    .hold_in (hold_w),
    .out_q   (par_out)
  );
endmodule

// File: rtl/s2p_byte_aligner_chk.sv
module s2p_byte_aligner_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pclk_out,
  input logic              pclk_fall,
  input logic [BYTE_W-1:0] par_out
);
  localparam int unsigned CNT_W = $clog2(BYTE_W) + 1;
  localparam int unsigned HALF  = BYTE_W / 2;

  logic [CNT_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (pclk_fall) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != {CNT_W{1'b1}}) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (par_out == '0) && pclk_out && !pclk_fall);

  a_r2_period: assert property (@(posedge clk) disable iff (rst)
    (pclk_fall && seen_q) |-> (gap_q == CNT_W'(BYTE_W - 1)));

  a_r2_duty: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (pclk_out == ((gap_q >= CNT_W'(HALF - 1)) && (gap_q <= CNT_W'(BYTE_W - 2)))));

  a_r3_fall_edge: assert property (@(posedge clk) disable iff (rst)
    pclk_fall |-> (!pclk_out && $past(pclk_out)));

  a_r4_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
    !pclk_fall |-> $stable(par_out));
endmodule

bind s2p_byte_aligner s2p_byte_aligner_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pclk_out  (pclk_out),
  .pclk_fall (pclk_fall),
  .par_out   (par_out)
);

// File: tb/test_s2p_byte_aligner.sv
module test_s2p_byte_aligner;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b0;
  logic       realign = 1'b0;
  logic       pclk_out;
  logic       pclk_fall;
  logic [7:0] par_out;

  always #10ns clk = ~clk;

  s2p_byte_aligner i_s2p_byte_aligner (
    .clk(clk), .rst(rst), .ser_in(ser_in), .realign(realign),
    .pclk_out(pclk_out), .pclk_fall(pclk_fall), .par_out(par_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  int         n = 0;
  int         ph = 0;
  logic [7:0] acc = '0;
  bit         pend = 0;
  logic [7:0] pend_val = '0;
  int         ready = 0;
  logic [7:0] hold_exp = '0;
  logic [7:0] exp_out = '0;
  logic [7:0] prev_out = '0;
  bit         seen_ra = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", req, n, act, exp);
    end
  endtask

  // at a negedge: check the state of cycle n, apply inputs of cycle n, advance
  task automatic step(input logic b, input logic ra);
    if (n % 8 == 4) exp_out = hold_exp;       // R8: hold as of cycle n-1
    if (pend && n >= ready) begin
      hold_exp = pend_val;
      pend = 0;
    end
    chk("R2", 32'(pclk_out), 32'((n % 8) < 4));
    chk("R3", 32'(pclk_fall), 32'((n % 8) == 4));
    if (seen_ra) chk("R7/R8", 32'(par_out), 32'(exp_out));
    else         chk("R6/R8", 32'(par_out), 32'(exp_out));
    if (!pclk_fall && n > 0) chk("R4", 32'(par_out), 32'(prev_out));
    prev_out = par_out;
    ser_in  = b;
    realign = ra;
    if (ra) begin
      seen_ra = 1;
      acc = {7'b0, b};
      ph = 1;
    end else begin
      acc = {acc[6:0], b};
      if (ph == 7) begin
        pend = 1;
        pend_val = acc;
        ready = n + 2;
        ph = 0;
      end else begin
        ph++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    n++;
  endtask

  task automatic send_byte(input logic [7:0] v, input bit first_ra);
    for (int i = 7; i >= 0; i--) step(v[i], (i == 7) && first_ra);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) begin
      @(negedge clk);
      ser_in = 1'($urandom);
      chk("R1", {pclk_out, pclk_fall, par_out}, {1'b1, 1'b0, 8'h00});
    end
    rst = 1'b0;
    chk("R1", {pclk_out, pclk_fall, par_out}, {1'b1, 1'b0, 8'h00});

    // R6: plain byte stream from reset, no realign
    send_byte(8'h3C, 0);
    send_byte(8'hC3, 0);
    send_byte(8'h96, 0);
    repeat (24) step(1'($urandom), 0);

    // R5/R9: realign at every phase of the byte clock, measure latency
    for (int p = 0; p < 8; p++) begin
      int k;
      int lat;
      logic [7:0] v;
      repeat (24) step(0, 0);
      while (n % 8 != p) step(0, 0);
      v = 8'h80 | 8'(p);
      k = n;
      send_byte(v, 1);
      lat = 0;
      while (par_out == 8'h00 && lat < 40) begin
        step(0, 0);
        lat = n - k;
      end
      chk("R5", 32'(par_out), 32'(v));
      checks++;
      if (lat < 10 || lat > 17) begin
        errors++;
        $display("FAIL R9 phase %0d actual latency %0d expected 10..17", p, lat);
      end
    end

    // R7: partial byte of ones discarded by realign, including at the last bit
    repeat (16) step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    send_byte(8'h42, 1);
    for (int i = 0; i < 7; i++) step(1, 0);
    send_byte(8'h24, 1);
    repeat (24) step(0, 0);

    // R7: mixed random stream with sparse realign pulses
    for (int i = 0; i < 3000; i++)
      step(1'($urandom), ($urandom % 37) == 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule